// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block collects eight interrupt request lines into a single interrupt output for a processor. Each line can be masked. A fixed priority picks the most urgent pending line, and a two-pulse acknowledge handshake from the processor returns an 8-bit vector that identifies that line. The block keeps three 8-bit registers: pending requests, lines in service and the mask. A line in service blocks every line of equal or lower priority until software, or the automatic mode, retires it.

Software reaches the block through a byte-wide register bus with two addresses. The command address (`reg_addr`=0) accepts initialization starts, end-of-interrupt commands and read-select commands. Reads at the command address return either the request or the in-service register. The data address (`reg_addr`=1) carries the later words of initialization. Outside initialization it reads and writes the mask. Reads are combinational from `reg_addr`.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the request and in-service registers are 0x00, the mask is 0xFF, command-address reads return the request register and `int_req` is low.
- R2: A command write with bit 4 set starts initialization. Bit 0 of that byte says whether a mode word follows, and bit 3 selects level triggering. The write clears the request and in-service registers, cancels auto end-of-interrupt and selects the request register for reads. It leaves the mask unchanged. The following data writes become, in turn, the vector base, the cascade word (shown on `cascade_cfg`) and, if announced, the mode word. Data writes change the mask again only after the last of these words.
- R3: Outside initialization, a data write loads the mask (bit n set masks line n), and a data read returns the last value written.
- R4: Command byte 0x0B makes command-address reads return the in-service register. Command byte 0x0A makes them return the request register.
- R5: Line 0 has the highest priority and line 7 the lowest. `int_req` is high exactly when some unmasked pending line has higher priority than every line set in the in-service register.
- R6: On the first `ack` pulse, the winning line's in-service bit is set and its request bit is cleared. On the second pulse, `vec_out` takes the vector base plus the 3-bit line number, and `vec_valid` is high for the one cycle after that pulse.
- R7: Command byte 0x60+n (n in 0..7) clears in-service bit n only.
- R8: When bit 1 of the mode word is set, the in-service bit of the granted line clears at the second `ack` pulse.
- R9: If no line qualifies at the first `ack` pulse, the vector is the base plus 7 and no in-service bit is set.
- R10: In edge mode a request is latched on a rising input edge, is held only while the input stays high, and is not raised again by an input that stays high after its acknowledge. In level mode the request follows the input.
- R11: A pending request on a masked line does not raise `int_req`, yet it still shows in the request register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 1 | 0 = command address, 1 = data address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq_in | input | 8 | Interrupt request lines |
| int_req | output | 1 | Interrupt output to the processor |
| ack | input | 1 | Acknowledge pulse, one cycle, two per interrupt |
| vec_out | output | 8 | Vector of the last acknowledged interrupt |
| vec_valid | output | 1 | High the cycle after the vector pulse |
| cascade_cfg | output | 8 | Stored cascade configuration word |

## Verification
Assertions check on every cycle that a fully masked block never requests and that the mask holds still during initialization. They also check that mask writes land exactly, that a specific end-of-interrupt leaves its bit clear, that a grant adds exactly one in-service bit, and that auto end-of-interrupt never grows the in-service set. Several behaviours can be shown only through the bench's scenarios: nested preemption by a higher line, the spurious line-7 vector after a request vanishes, edge re-arming against level re-requesting, and the shortened three-word initialization. For these the bench tracks the vectors through its scoreboard queue and reads the registers back.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [DW-1:0] irq_in,
  output logic          int_req,
  input  logic          ack,
  output logic [DW-1:0] vec_out,
  output logic          vec_valid,
  output logic [DW-1:0] cascade_cfg
);
  localparam int LVL_W = $clog2(DW);

  logic [DW-1:0] irr, isr, imr, irq_q, vbase, casc;
  logic [1:0] step;
  logic need4, lvl_mode, aeoi, rsel, phase, spur;
  logic [LVL_W-1:0] grant, win;

  logic cmd_wr, dat_wr, icw1, ocw, eoi, ack_grant, ack_vec;
  logic [DW-1:0] isr_low, allowed, pend, irr_nx, isr_set, isr_clr;

  assign cmd_wr = reg_wr & ~reg_addr;
  assign dat_wr = reg_wr & reg_addr;
  assign icw1   = cmd_wr & reg_wdata[4];
  assign ocw    = cmd_wr & ~reg_wdata[4];
  assign eoi    = ocw & (reg_wdata[7:3] == 5'b01100);

  assign isr_low = isr & (~isr + DW'(1));
  assign allowed = (isr == '0) ? '1 : isr_low - DW'(1);
  assign pend    = irr & ~imr & allowed;
  assign int_req = |pend;

  always_comb begin
    win = '0;
    for (int i = DW - 1; i >= 0; i--)
      if (pend[i]) win = LVL_W'(i);
  end

  assign ack_grant = ack & ~phase & (|pend);
  assign ack_vec   = ack & phase;

  assign irr_nx  = lvl_mode ? irq_in : (irr | (irq_in & ~irq_q)) & irq_in;
  assign isr_set = ack_grant ? (DW'(1) << win) : '0;
  assign isr_clr = (eoi ? (DW'(1) << reg_wdata[2:0]) : '0)
                 | ((ack_vec & aeoi & ~spur) ? (DW'(1) << grant) : '0);

  assign reg_rdata   = reg_addr ? imr : (rsel ? isr : irr);
  assign cascade_cfg = casc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step <= '0; need4 <= 1'b0; lvl_mode <= 1'b0; aeoi <= 1'b0; rsel <= 1'b0;
      imr <= '1; vbase <= '0; casc <= '0;
    end else begin
      if (icw1) begin
        step <= 2'd1; need4 <= reg_wdata[0]; lvl_mode <= reg_wdata[3];
        aeoi <= 1'b0; rsel <= 1'b0;
      end else if (ocw && reg_wdata == 8'h0A) begin
        rsel <= 1'b0;
      end else if (ocw && reg_wdata == 8'h0B) begin
        rsel <= 1'b1;
      end
      if (dat_wr) begin
        case (step)
          2'd0: imr <= reg_wdata;
          2'd1: begin vbase <= reg_wdata; step <= 2'd2; end
          2'd2: begin casc <= reg_wdata; step <= need4 ? 2'd3 : 2'd0; end
          default: begin aeoi <= reg_wdata[1]; step <= 2'd0; end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr <= '0; isr <= '0; irq_q <= '0; phase <= 1'b0; spur <= 1'b0;
      grant <= '0; vec_out <= '0; vec_valid <= 1'b0;
    end else begin
      irq_q     <= irq_in;
      vec_valid <= ack_vec;
      if (icw1) begin
        irr <= '0; isr <= '0; phase <= 1'b0;
      end else begin
        irr <= irr_nx & ~isr_set;
        isr <= (isr & ~isr_clr) | isr_set;
        if (ack) phase <= ~phase;
      end
      if (ack && !phase) begin
        grant <= (|pend) ? win : '1;
        spur  <= ~(|pend);
      end
      if (ack_vec) vec_out <= vbase + DW'(grant);
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic       reg_addr,
  input logic [7:0] reg_wdata,
  input logic       ack,
  input logic       int_req,
  input logic [7:0] imr,
  input logic [7:0] isr,
  input logic [1:0] step,
  input logic       phase,
  input logic       aeoi
);
  a_r5_full_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (imr == 8'hFF) |-> !int_req);

  a_r2_mask_held_in_init: assert property (@(posedge clk) disable iff (!rst_n)
    (step != 2'd0) |=> (imr == $past(imr)));

  a_r3_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr && step == 2'd0) |=> (imr == $past(reg_wdata)));

  a_r7_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr && reg_wdata[7:3] == 5'b01100 && !ack)
      |=> !isr[$past(reg_wdata[2:0])]);

  a_r6_grant_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !phase && int_req && !reg_wr)
      |=> ($countones(isr) == $countones($past(isr)) + 1));

  a_r8_aeoi_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && phase && aeoi && !reg_wr)
      |=> ($countones(isr) <= $countones($past(isr))));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .ack(ack), .int_req(int_req), .imr(imr),
  .isr(isr), .step(step), .phase(phase), .aeoi(aeoi)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_addr = 1'b0, ack = 1'b0;
  logic [7:0] reg_wdata = '0, irq_in = '0;
  logic [7:0] reg_rdata, vec_out, cascade_cfg;
  logic int_req, vec_valid;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
    .int_req(int_req), .ack(ack), .vec_out(vec_out), .vec_valid(vec_valid),
    .cascade_cfg(cascade_cfg)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic do_ack(input logic [7:0] exp_vec);
    exp_q.push_back(exp_vec);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (vec_valid) begin
      if (exp_q.size() == 0) check("R6 unexpected vector", vec_out, 8'hxx);
      else check("R6 vector", vec_out, exp_q.pop_front());
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    idle(3); rst_n = 1'b1;
    rd(1'b0, v); check("R1 request reg", v, 8'h00);
    rd(1'b1, v); check("R1 mask", v, 8'hFF);
    check("R1 int_req", {7'b0, int_req}, 8'h00);

    // R2: edge mode, four words, normal EOI
    wr(1'b0, 8'h11); wr(1'b1, 8'h40); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    rd(1'b1, v); check("R2 mask untouched", v, 8'hFF);
    check("R2 cascade word", cascade_cfg, 8'h04);

    wr(1'b1, 8'h5A); rd(1'b1, v); check("R3 mask readback", v, 8'h5A);
    wr(1'b1, 8'h00); rd(1'b1, v); check("R3 mask readback", v, 8'h00);

    // R5 / R6 / R4 nesting
    @(negedge clk); irq_in = 8'h28; idle(2);
    check("R5 int_req", {7'b0, int_req}, 8'h01);
    rd(1'b0, v); check("R4 request reg", v, 8'h28);
    do_ack(8'h43);
    wr(1'b0, 8'h0B); rd(1'b0, v); check("R6 in-service", v, 8'h08);
    check("R5 blocked by in-service", {7'b0, int_req}, 8'h00);
    @(negedge clk); irq_in = 8'h22; idle(2);
    check("R5 higher preempts", {7'b0, int_req}, 8'h01);
    do_ack(8'h41);
    rd(1'b0, v); check("R6 nested in-service", v, 8'h0A);
    wr(1'b0, 8'h61); rd(1'b0, v); check("R7 clears only bit1", v, 8'h08);
    wr(1'b0, 8'h63); rd(1'b0, v); check("R7 clears bit3", v, 8'h00);
    idle(1); check("R5 line 5 now", {7'b0, int_req}, 8'h01);
    do_ack(8'h45); wr(1'b0, 8'h65); idle(2);
    check("R10 edge no re-request", {7'b0, int_req}, 8'h00);
    @(negedge clk); irq_in = 8'h00; idle(2);

    // R11 masked line
    wr(1'b1, 8'h01);
    @(negedge clk); irq_in = 8'h01; idle(2);
    check("R11 masked quiet", {7'b0, int_req}, 8'h00);
    wr(1'b0, 8'h0A); rd(1'b0, v); check("R11 still pending", v, 8'h01);
    wr(1'b1, 8'h00); idle(1);
    check("R11 unmasked", {7'b0, int_req}, 8'h01);
    do_ack(8'h40); wr(1'b0, 8'h60);
    @(negedge clk); irq_in = 8'h00; idle(2);

    // R9 spurious
    @(negedge clk); irq_in = 8'h04; idle(2);
    check("R9 request seen", {7'b0, int_req}, 8'h01);
    @(negedge clk); irq_in = 8'h00; idle(2);
    do_ack(8'h47);
    wr(1'b0, 8'h0B); rd(1'b0, v); check("R9 no in-service", v, 8'h00);

    // R8 / R10 level mode with auto EOI
    wr(1'b0, 8'h19); wr(1'b1, 8'h80); wr(1'b1, 8'h00); wr(1'b1, 8'h03);
    @(negedge clk); irq_in = 8'h10; idle(2);
    check("R10 level request", {7'b0, int_req}, 8'h01);
    do_ack(8'h84);
    wr(1'b0, 8'h0B); rd(1'b0, v); check("R8 auto cleared", v, 8'h00);
    idle(1); check("R10 level re-request", {7'b0, int_req}, 8'h01);
    do_ack(8'h84);
    @(negedge clk); irq_in = 8'h00; idle(2);
    check("R10 level drop", {7'b0, int_req}, 8'h00);

    // R2 three-word sequence
    wr(1'b0, 8'h10); wr(1'b1, 8'h20); wr(1'b1, 8'h00);
    wr(1'b1, 8'h33); rd(1'b1, v); check("R2 short init then mask", v, 8'h33);

    idle(3);
    check("R6 all vectors seen", 8'(exp_q.size()), 8'h00);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule